// File: doc/BRIEF.md
# Accumulator Machine with Register-Transfer Control

A small accumulator processor whose control unit runs every instruction as a fixed chain of single register transfers. The machine holds a program counter, an instruction register, an address register, a data register, an accumulator with a negative flag, and an output register. Memory is external: a synchronous single-port array of 100 ten-bit words at addresses 00 to 99. The address output always shows the address register, and the write-data output always shows the data register. Memory is reached through no other path.

A word holds a value from 0 to 999, read as three decimal digits. The hundreds digit selects the operation and the low two digits give an operand address. Every instruction takes the same fetch steps. Only the execute step depends on the opcode. Arithmetic wraps modulo 1000. A subtraction that underflows sets the negative flag, and the conditional branches test the accumulator or that flag. An input instruction waits on a valid/ready handshake. An output instruction loads the output register and pulses a strobe. HALT freezes the machine until reset.

Top module: `acc_cpu`

## Requirements
- R1: While rst_ni is low and just after it is released, halted_o, out_strobe_o, in_ready_o and mem_we_o are 0. The program counter and accumulator are 0, so the first fetch presents address 0.
- R2: Each instruction is fetched in fixed microsteps. First the program counter is copied to the address register. Then the word read from memory is captured in the data register and moved to the instruction register. The hundreds digit is the opcode and the low two digits are the operand address.
- R3: Opcode 5 (load) reads the operand address and copies the data register into the accumulator, then advances the program counter.
- R4: Opcode 3 (store) puts the operand address in the address register and the accumulator in the data register. It then raises mem_we_o for exactly one cycle and advances the program counter.
- R5: Opcode 1 (add) sets the accumulator to (accumulator + operand) mod 1000. The negative flag is cleared.
- R6: Opcode 2 (subtract) sets the accumulator to (accumulator − operand) mod 1000. The negative flag is set when the operand is larger than the accumulator. Any later load, add or input clears the flag.
- R7: Word 901 (input) raises in_ready_o and stays in that step until in_valid_i is high. It then loads in_data_i into the accumulator, and in_ready_o drops in the next cycle.
- R8: Word 902 (output) loads the accumulator into out_data_o. out_strobe_o is high for exactly one cycle, with the new value.
- R9: Opcode 6 loads the program counter with the operand address, with no increment.
- R10: Opcode 7 branches when the accumulator is 0 and otherwise advances the program counter.
- R11: Opcode 8 branches when the negative flag is clear and otherwise advances the program counter.
- R12: Advancing the program counter from 99 gives 0. mem_addr_o never exceeds 99.
- R13: Opcode 0 (halt) sets halted_o. After that, until reset, no memory write occurs, no strobe fires, in_ready_o stays low and out_data_o does not change.
- R14: Opcode 4, and opcode 9 with low digits other than 01 or 02, change no register except the program counter, which advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 7 | Memory address (address register) |
| mem_wdata_o | output | 10 | Memory write data (data register) |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 10 | Memory read data, valid one cycle after the address |
| in_data_i | input | 10 | Input port data |
| in_valid_i | input | 1 | Input port data valid |
| in_ready_o | output | 1 | Input instruction is waiting for data |
| out_data_o | output | 10 | Output register |
| out_strobe_o | output | 1 | One-cycle pulse when the output register is loaded |
| halted_o | output | 1 | Machine has halted |

## Verification
The assertions assume that the memory returns the word at the presented address one cycle later and that every word it holds is at most 999. They also assume that in_data_i is at most 999 whenever in_valid_i is high, and that in_valid_i is asserted only while in_ready_o is high. The bench models the memory as such a registered array and loads only legal words. Random operands are drawn from 0 to 999. The input driver raises valid only after it sees in_ready_o, holds it for one cycle, and inserts a chosen number of wait cycles before doing so.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int unsigned WORD_W    = 10;
  localparam int unsigned ADDR_W    = 7;
  localparam int unsigned MEM_DEPTH = 100;
  localparam int unsigned WORD_MOD  = 1000;

  localparam logic [3:0] OP_HALT = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_STO  = 4'd3;
  localparam logic [3:0] OP_LDA  = 4'd5;
  localparam logic [3:0] OP_BRA  = 4'd6;
  localparam logic [3:0] OP_BRZ  = 4'd7;
  localparam logic [3:0] OP_BRP  = 4'd8;
  localparam logic [3:0] OP_IO   = 4'd9;

  typedef enum logic [3:0] {
    ST_F_ADDR, ST_F_WAIT, ST_F_CAP, ST_F_IR, ST_DEC,
    ST_O_WAIT, ST_O_CAP, ST_EXEC, ST_S_DATA, ST_S_WR,
    ST_IN, ST_OUT, ST_PC_INC, ST_HALT
  } state_e;

  typedef enum logic [1:0] {PC_HOLD, PC_STEP, PC_JUMP} pc_sel_e;
  typedef enum logic [2:0] {ACC_HOLD, ACC_MDR, ACC_ADD, ACC_SUB, ACC_IN} acc_sel_e;

  typedef struct packed {
    pc_sel_e  pc_sel;
    logic     mar_pc;
    logic     mar_ir;
    logic     mdr_mem;
    logic     mdr_acc;
    logic     ir_ld;
    acc_sel_e acc_sel;
    logic     out_ld;
    logic     mem_we;
  } ctl_t;
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int unsigned WORD_W   = 10,
  parameter int unsigned WORD_MOD = 1000
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              sub_i,
  output logic [WORD_W-1:0] res_o,
  output logic              borrow_o
);
  localparam logic [WORD_W:0] MOD_W = (WORD_W+1)'(WORD_MOD);

  logic [WORD_W:0] a_x, b_x, sum_x, dif_x;

  always_comb begin
    a_x      = {1'b0, a_i};
    b_x      = {1'b0, b_i};
    sum_x    = a_x + b_x;
    dif_x    = a_x - b_x;
    borrow_o = 1'b0;
    if (sub_i) begin
      if (a_x < b_x) begin
        dif_x    = a_x + MOD_W - b_x;
        borrow_o = 1'b1;
      end
      res_o = dif_x[WORD_W-1:0];
    end else begin
      if (sum_x >= MOD_W) sum_x = sum_x - MOD_W;
      res_o = sum_x[WORD_W-1:0];
    end
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        ir_op_i,
  input  logic [ADDR_W-1:0] ir_lo_i,
  input  logic              acc_zero_i,
  input  logic              neg_i,
  input  logic              in_valid_i,
  output ctl_t              ctl_o,
  output logic              in_ready_o,
  output logic              halted_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_F_ADDR;
    else         state_q <= state_d;
  end

  always_comb begin
    ctl_o   = '0;
    state_d = state_q;
    unique case (state_q)
      ST_F_ADDR: begin ctl_o.mar_pc  = 1'b1; state_d = ST_F_WAIT; end
      ST_F_WAIT: state_d = ST_F_CAP;
      ST_F_CAP:  begin ctl_o.mdr_mem = 1'b1; state_d = ST_F_IR; end
      ST_F_IR:   begin ctl_o.ir_ld   = 1'b1; state_d = ST_DEC; end
      ST_DEC: begin
        case (ir_op_i)
          OP_ADD, OP_SUB, OP_LDA: begin ctl_o.mar_ir = 1'b1; state_d = ST_O_WAIT; end
          OP_STO: begin ctl_o.mar_ir = 1'b1; state_d = ST_S_DATA; end
          OP_BRA: begin ctl_o.pc_sel = PC_JUMP; state_d = ST_F_ADDR; end
          OP_BRZ: begin
            ctl_o.pc_sel = acc_zero_i ? PC_JUMP : PC_STEP;
            state_d      = ST_F_ADDR;
          end
          OP_BRP: begin
            ctl_o.pc_sel = neg_i ? PC_STEP : PC_JUMP;
            state_d      = ST_F_ADDR;
          end
          OP_IO: begin
            if (ir_lo_i == ADDR_W'(1))      state_d = ST_IN;
            else if (ir_lo_i == ADDR_W'(2)) state_d = ST_OUT;
            else                            state_d = ST_PC_INC;
          end
          OP_HALT: state_d = ST_HALT;
          default: state_d = ST_PC_INC;
        endcase
      end
      ST_O_WAIT: state_d = ST_O_CAP;
      ST_O_CAP:  begin ctl_o.mdr_mem = 1'b1; state_d = ST_EXEC; end
      ST_EXEC: begin
        case (ir_op_i)
          OP_ADD:  ctl_o.acc_sel = ACC_ADD;
          OP_SUB:  ctl_o.acc_sel = ACC_SUB;
          default: ctl_o.acc_sel = ACC_MDR;
        endcase
        state_d = ST_PC_INC;
      end
      ST_S_DATA: begin ctl_o.mdr_acc = 1'b1; state_d = ST_S_WR; end
      ST_S_WR:   begin ctl_o.mem_we  = 1'b1; state_d = ST_PC_INC; end
      ST_IN: begin
        if (in_valid_i) begin
          ctl_o.acc_sel = ACC_IN;
          state_d       = ST_PC_INC;
        end
      end
      ST_OUT:    begin ctl_o.out_ld = 1'b1; state_d = ST_PC_INC; end
      ST_PC_INC: begin ctl_o.pc_sel = PC_STEP; state_d = ST_F_ADDR; end
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_F_ADDR;
    endcase
  end

  assign in_ready_o = (state_q == ST_IN);
  assign halted_o   = (state_q == ST_HALT);
endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter int unsigned WORD_W    = 10,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned MEM_DEPTH = 100,
  parameter int unsigned WORD_MOD  = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [WORD_W-1:0] mdr_o,
  output logic [3:0]        ir_op_o,
  output logic [ADDR_W-1:0] ir_lo_o,
  output logic              acc_zero_o,
  output logic              neg_o,
  output logic [WORD_W-1:0] out_o,
  output logic              strobe_o
);
  localparam logic [ADDR_W-1:0] PC_LAST = ADDR_W'(MEM_DEPTH - 1);
  localparam int unsigned       FIELD   = WORD_MOD / 10;

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [WORD_W-1:0] mdr_q, ir_q, acc_q, out_q;
  logic              neg_q, strobe_q;
  logic [WORD_W-1:0] alu_res;
  logic              alu_borrow;

  acc_cpu_alu #(.WORD_W(WORD_W), .WORD_MOD(WORD_MOD)) u_alu (
    .a_i      (acc_q),
    .b_i      (mdr_q),
    .sub_i    (ctl_i.acc_sel == ACC_SUB),
    .res_o    (alu_res),
    .borrow_o (alu_borrow)
  );

  assign ir_op_o = 4'(ir_q / WORD_W'(FIELD));
  assign ir_lo_o = ADDR_W'(ir_q % WORD_W'(FIELD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      mar_q    <= '0;
      mdr_q    <= '0;
      ir_q     <= '0;
      acc_q    <= '0;
      neg_q    <= 1'b0;
      out_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= ctl_i.out_ld;
      case (ctl_i.pc_sel)
        PC_STEP: pc_q <= (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
        PC_JUMP: pc_q <= ir_lo_o;
        default: ;
      endcase
      if (ctl_i.mar_pc) mar_q <= pc_q;
      if (ctl_i.mar_ir) mar_q <= ir_lo_o;
      if (ctl_i.mdr_mem) mdr_q <= mem_rdata_i;
      if (ctl_i.mdr_acc) mdr_q <= acc_q;
      if (ctl_i.ir_ld)   ir_q  <= mdr_q;
      if (ctl_i.out_ld)  out_q <= acc_q;
      case (ctl_i.acc_sel)
        ACC_MDR: begin acc_q <= mdr_q;     neg_q <= 1'b0; end
        ACC_IN:  begin acc_q <= in_data_i; neg_q <= 1'b0; end
        ACC_ADD: begin acc_q <= alu_res;   neg_q <= 1'b0; end
        ACC_SUB: begin acc_q <= alu_res;   neg_q <= alu_borrow; end
        default: ;
      endcase
    end
  end

  assign mar_o      = mar_q;
  assign mdr_o      = mdr_q;
  assign acc_zero_o = (acc_q == '0);
  assign neg_o      = neg_q;
  assign out_o      = out_q;
  assign strobe_o   = strobe_q;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned P_WORD_W    = WORD_W,
  parameter int unsigned P_ADDR_W    = ADDR_W,
  parameter int unsigned P_MEM_DEPTH = MEM_DEPTH,
  parameter int unsigned P_WORD_MOD  = WORD_MOD
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [P_ADDR_W-1:0]   mem_addr_o,
  output logic [P_WORD_W-1:0]   mem_wdata_o,
  output logic                  mem_we_o,
  input  logic [P_WORD_W-1:0]   mem_rdata_i,
  input  logic [P_WORD_W-1:0]   in_data_i,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  output logic [P_WORD_W-1:0]   out_data_o,
  output logic                  out_strobe_o,
  output logic                  halted_o
);
  ctl_t                ctl;
  logic [3:0]          ir_op;
  logic [P_ADDR_W-1:0] ir_lo;
  logic                acc_zero, neg;

  acc_cpu_ctrl #(.ADDR_W(P_ADDR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ir_op_i    (ir_op),
    .ir_lo_i    (ir_lo),
    .acc_zero_i (acc_zero),
    .neg_i      (neg),
    .in_valid_i (in_valid_i),
    .ctl_o      (ctl),
    .in_ready_o (in_ready_o),
    .halted_o   (halted_o)
  );

  acc_cpu_dp #(
    .WORD_W(P_WORD_W), .ADDR_W(P_ADDR_W),
    .MEM_DEPTH(P_MEM_DEPTH), .WORD_MOD(P_WORD_MOD)
  ) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (ctl),
    .mem_rdata_i (mem_rdata_i),
    .in_data_i   (in_data_i),
    .mar_o       (mem_addr_o),
    .mdr_o       (mem_wdata_o),
    .ir_op_o     (ir_op),
    .ir_lo_o     (ir_lo),
    .acc_zero_o  (acc_zero),
    .neg_o       (neg),
    .out_o       (out_data_o),
    .strobe_o    (out_strobe_o)
  );

  assign mem_we_o = ctl.mem_we;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int unsigned P_WORD_W    = 10,
  parameter int unsigned P_ADDR_W    = 7,
  parameter int unsigned P_MEM_DEPTH = 100
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [P_ADDR_W-1:0] mem_addr_o,
  input logic                mem_we_o,
  input logic                in_valid_i,
  input logic                in_ready_o,
  input logic [P_WORD_W-1:0] out_data_o,
  input logic                out_strobe_o,
  input logic                halted_o
);
  p_idle_in_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!halted_o && !mem_we_o && !out_strobe_o && !in_ready_o));

  p_write_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  p_in_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i) |=> in_ready_o);

  p_in_take_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && in_valid_i) |=> !in_ready_o);

  p_strobe_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_strobe_o |=> !out_strobe_o);

  p_addr_range_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_addr_o <= P_ADDR_W'(P_MEM_DEPTH - 1));

  p_halt_sticky_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && !mem_we_o && !out_strobe_o && !in_ready_o));

  p_halt_out_frozen_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(out_data_o));
endmodule

bind acc_cpu acc_cpu_chk #(
  .P_WORD_W(P_WORD_W), .P_ADDR_W(P_ADDR_W), .P_MEM_DEPTH(P_MEM_DEPTH)
) u_chk (.*);

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] mem_addr_o;
  logic [9:0] mem_wdata_o;
  logic       mem_we_o;
  logic [9:0] mem_rdata = '0;
  logic [9:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready_o;
  logic [9:0] out_data_o;
  logic       out_strobe_o;
  logic       halted_o;

  int total = 0;
  int bad = 0;

  logic [9:0] mem [0:127];
  int out_buf [0:15];
  int out_n = 0;
  int wr_n = 0;
  int wr_addr = 0;
  int wr_data = 0;
  int in_q [0:7];
  int in_n = 0;
  int in_idx = 0;
  int in_delay = 0;
  int delay_cnt = 0;
  int wait_cyc = 0;

  always #5 clk = ~clk;

  acc_cpu dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
    .mem_rdata_i(mem_rdata),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready_o),
    .out_data_o(out_data_o), .out_strobe_o(out_strobe_o), .halted_o(halted_o)
  );

  // registered-read memory model
  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    mem_rdata <= mem[mem_addr_o];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_strobe_o && out_n < 16) begin
        out_buf[out_n] = int'(out_data_o);
        out_n++;
      end
      if (mem_we_o) begin
        wr_n++;
        wr_addr = int'(mem_addr_o);
        wr_data = int'(mem_wdata_o);
      end
      if (in_ready_o && !in_valid) wait_cyc++;
      if (in_valid) in_valid = 1'b0;
      else if (in_ready_o && in_idx < in_n) begin
        if (delay_cnt > 0) delay_cnt--;
        else begin
          in_data   = 10'(in_q[in_idx]);
          in_valid  = 1'b1;
          in_idx++;
          delay_cnt = in_delay;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int f_add(input int a, input int b);
    return (a + b) % 1000;
  endfunction

  function automatic int f_sub(input int a, input int b);
    return (a >= b) ? a - b : a + 1000 - b;
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 128; i++) mem[i] = '0;
    out_n = 0; wr_n = 0; in_n = 0; in_idx = 0; wait_cyc = 0;
    delay_cnt = in_delay;
  endtask

  task automatic run(input string req);
    int cyc;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted_o && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(halted_o, req, cyc, 3000);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a, b, x;
    void'($urandom(32'd2718));
    for (int i = 0; i < 128; i++) mem[i] = '0;

    // R1: reset state
    repeat (2) @(negedge clk);
    chk(!halted_o && !out_strobe_o && !in_ready_o && !mem_we_o, "R1 reset outputs",
        {halted_o, out_strobe_o, in_ready_o, mem_we_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_addr_o == 7'd0, "R1 first fetch address", int'(mem_addr_o), 0);

    // R2 R3 R4 R5 R8: load, add, store, out
    for (int t = 0; t < 6; t++) begin
      a = (t == 0) ? 999 : int'($urandom % 1000);
      b = (t == 0) ? 1 : int'($urandom % 1000);
      clear_mem();
      mem[0] = 10'd510; mem[1] = 10'd111; mem[2] = 10'd312;
      mem[3] = 10'd902; mem[4] = 10'd000;
      mem[10] = 10'(a); mem[11] = 10'(b);
      run("R2 halt reached");
      chk(out_n == 1 && out_buf[0] == f_add(a, b), "R5 add output", out_buf[0], f_add(a, b));
      chk(int'(mem[12]) == f_add(a, b), "R4 stored word", int'(mem[12]), f_add(a, b));
      chk(wr_n == 1 && wr_addr == 12, "R4 single write", wr_n * 100 + wr_addr, 112);
      chk(int'(out_data_o) == f_add(a, b), "R8 output register", int'(out_data_o), f_add(a, b));
    end

    // R6 R11: subtract with borrow and branch on not negative
    for (int t = 0; t < 6; t++) begin
      a = int'($urandom % 1000);
      b = (t < 3) ? int'($urandom % 1000) : ((t == 3) ? a : a + 1);
      if (b > 999) b = 0;
      clear_mem();
      mem[0] = 10'd510; mem[1] = 10'd211; mem[2] = 10'd902; mem[3] = 10'd806;
      mem[4] = 10'd520; mem[5] = 10'd902; mem[6] = 10'd000;
      mem[10] = 10'(a); mem[11] = 10'(b); mem[20] = 10'd777;
      run("R6 halt reached");
      chk(out_buf[0] == f_sub(a, b), "R6 subtract result", out_buf[0], f_sub(a, b));
      x = (a < b) ? 2 : 1;
      chk(out_n == x, "R11 branch on flag", out_n, x);
    end

    // R6: flag cleared by a later load
    clear_mem();
    mem[0] = 10'd510; mem[1] = 10'd211; mem[2] = 10'd512; mem[3] = 10'd806;
    mem[4] = 10'd902; mem[5] = 10'd000; mem[6] = 10'd513; mem[7] = 10'd902;
    mem[8] = 10'd000;
    mem[10] = 10'd5; mem[11] = 10'd9; mem[12] = 10'd3; mem[13] = 10'd42;
    run("R6 halt reached");
    chk(out_n == 1 && out_buf[0] == 42, "R6 flag clear on load", out_buf[0], 42);

    // R7 R9 R10: input, branch if zero, unconditional branch
    for (int t = 0; t < 4; t++) begin
      x = (t == 0) ? 0 : int'($urandom % 999) + 1;
      in_delay = t;
      clear_mem();
      in_q[0] = x; in_n = 1;
      mem[0] = 10'd901; mem[1] = 10'd705; mem[2] = 10'd902; mem[3] = 10'd610;
      mem[4] = 10'd902; mem[5] = 10'd520; mem[6] = 10'd902; mem[7] = 10'd000;
      mem[10] = 10'd000; mem[20] = 10'd123;
      run("R7 halt reached");
      if (x == 0) chk(out_n == 1 && out_buf[0] == 123, "R10 zero taken", out_buf[0], 123);
      else begin
        chk(out_n == 1 && out_buf[0] == x, "R7 input value", out_buf[0], x);
        chk(out_n == 1, "R9 branch skips next", out_n, 1);
      end
      chk(wait_cyc >= t + 1, "R7 wait for valid", wait_cyc, t + 1);
    end
    in_delay = 0;

    // R12 R14: wrap from 99 to 0, undefined codes step over
    clear_mem();
    mem[0] = 10'd712; mem[1] = 10'd998; mem[2] = 10'd499; mem[3] = 10'd902;
    mem[4] = 10'd000; mem[12] = 10'd520; mem[13] = 10'd699; mem[99] = 10'd902;
    mem[20] = 10'd7;
    run("R12 halt reached");
    chk(out_n == 2 && out_buf[0] == 7 && out_buf[1] == 7, "R12 wrap and R14 no-op",
        out_n, 2);
    chk(wr_n == 0, "R14 no write", wr_n, 0);

    // R13: frozen after halt
    begin
      int w0, o0;
      logic [9:0] d0;
      w0 = wr_n; o0 = out_n; d0 = out_data_o;
      in_q[0] = 5; in_n = 1; in_idx = 0;
      repeat (30) @(negedge clk);
      chk(halted_o && !in_ready_o, "R13 stays halted", {halted_o, in_ready_o}, 2);
      chk(wr_n == w0 && out_n == o0 && out_data_o == d0, "R13 frozen",
          wr_n + out_n, w0 + o0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule